// File: doc/BRIEF.md
# Interrupt Status and Abort-Cause Register Block

This block collects the event indications of a two-wire serial bus controller into a raw status register. It combines that register with a programmable enable mask and drives one interrupt line. Ten of the twelve sources are single-cycle event pulses. Once set, such a bit stays set until software reads a clear address. Each source has its own clear address, so software can acknowledge exactly the events it has serviced without losing one that arrived in the meantime. The receive-full and transmit-empty sources are not pulses: they mirror level conditions of the data queues.

A separate cause word records why a transfer was abandoned. Cause bits accumulate until software reads the clear address of the transfer-abort source, or the combined clear address. Software therefore reads the cause word first and then acknowledges the abort.

Register access is a simple port. A read strobe with an address returns data in the same cycle, and any clearing side effect of that read takes effect at the clock edge that ends the read. A write strobe updates the mask.

Top module: `intr_status_block`

## Requirements
- R1: A pulse on `srcIn` bit i sets raw status bit i for every source except bits 2 and 4. The raw word reads at address 0x00 from the cycle after the pulse. Bit meanings: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transfer abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R2: Address 0x02 reads raw AND mask, and `irq` is high exactly when that masked value is nonzero.
- R3: Once set, a pulse-source raw bit stays set on every later cycle until a clear read for it occurs.
- R4: A read of address 0x10+i returns the current value of raw bit i in data bit 0, and clears raw bit i only; no other raw bit changes.
- R5: A read of address 0x03 returns the raw word and clears every pulse-source raw bit and the whole cause word.
- R6: Raw bits 2 and 4 equal `srcIn` bits 2 and 4 from the previous cycle, and no clear read changes them.
- R7: The cause word at address 0x04 is the bitwise OR of every `causeIn` value since it was last cleared. Only a read of 0x16 or 0x03 clears it. Cause bits: 0 seven-bit address not acknowledged, 1 first ten-bit address byte not acknowledged, 2 second ten-bit address byte not acknowledged, 3 data not acknowledged, 4 general call not acknowledged, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart off, 10 ten-bit read with restart off, 11 use while disabled, 12 arbitration lost.
- R8: After reset the mask at address 0x01 reads 0x254, which enables receive full, transmit empty, transfer abort and stop seen. A write to 0x01 loads data bits 11:0, and data bits 31:12 of the mask always read as zero.
- R9: If a source pulse, or a cause bit, arrives in the same cycle as the read that clears it, that bit is set afterwards.
- R10: A read of an address that is not listed above returns zero. Reads of 0x00, 0x01, 0x02 and 0x04 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 12 | Source indications; bits 2 and 4 are levels, all others single-cycle pulses |
| causeIn | input | 13 | Abort cause bits to accumulate |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 6 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request, high while any masked status bit is set |

## Verification
The bench builds the block with its default sizes: twelve sources, a thirteen-bit cause word and a six-bit address. At these sizes every source can be set, observed and cleared one at a time. It can also be cleared while all the others stay set, every single-bit mask can be tried, and every cause bit can be accumulated and cleared. Reads that race an arriving event are driven directly, so the bit that survives can be observed on the next read.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;

  localparam int unsigned SRC_N      = 12;
  localparam int unsigned CAUSE_N    = 13;
  localparam int unsigned IDX_W      = $clog2(SRC_N);

  // source positions that a neighbour decodes
  localparam int unsigned RXFULL_BIT  = 2;
  localparam int unsigned TXEMPTY_BIT = 4;
  localparam int unsigned TXABRT_BIT  = 6;

  localparam logic [SRC_N-1:0] LEVEL_SRC  = SRC_N'((1 << RXFULL_BIT) | (1 << TXEMPTY_BIT));
  localparam logic [SRC_N-1:0] MASK_RESET = 12'h254;

  // register word addresses
  localparam int unsigned ADDR_RAW     = 0;
  localparam int unsigned ADDR_MASK    = 1;
  localparam int unsigned ADDR_STAT    = 2;
  localparam int unsigned ADDR_CLR_ALL = 3;
  localparam int unsigned ADDR_CAUSE   = 4;
  localparam int unsigned CLR_BASE     = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASK,
    SEL_STAT,
    SEL_CAUSE,
    SEL_CLR_ONE,
    SEL_CLR_ALL
  } rdSel_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic [SRC_N-1:0] clrSrc;
    logic             clrCause;
    logic             maskWr;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] srcIdx;
  } strobes_t;

endpackage

// File: rtl/intr_status_decode.sv
module intr_status_decode
  import intr_status_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);

  always_comb begin
    stb        = '0;
    stb.rdSel  = SEL_NONE;
    stb.maskWr = wrEn && (addr == ADDR_W'(ADDR_MASK));

    if (rdEn) begin
      if (addr == ADDR_W'(ADDR_RAW)) begin
        stb.rdSel = SEL_RAW;
      end else if (addr == ADDR_W'(ADDR_MASK)) begin
        stb.rdSel = SEL_MASK;
      end else if (addr == ADDR_W'(ADDR_STAT)) begin
        stb.rdSel = SEL_STAT;
      end else if (addr == ADDR_W'(ADDR_CAUSE)) begin
        stb.rdSel = SEL_CAUSE;
      end else if (addr == ADDR_W'(ADDR_CLR_ALL)) begin
        stb.rdSel    = SEL_CLR_ALL;
        stb.clrSrc   = ~LEVEL_SRC;
        stb.clrCause = 1'b1;
      end

      // one read-to-clear address per source
      for (int i = 0; i < SRC_N; i++) begin
        if (addr == ADDR_W'(CLR_BASE + i)) begin
          stb.rdSel  = SEL_CLR_ONE;
          stb.srcIdx = IDX_W'(i);
          if (!LEVEL_SRC[i]) stb.clrSrc[i] = 1'b1;
          if (i == TXABRT_BIT) stb.clrCause = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/intr_status_regs.sv
module intr_status_regs
  import intr_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [SRC_N-1:0]   srcIn,
  input  logic [CAUSE_N-1:0] causeIn,
  input  logic [SRC_N-1:0]   maskIn,
  output logic [SRC_N-1:0]   rawQ,
  output logic [SRC_N-1:0]   maskQ,
  output logic [CAUSE_N-1:0] causeQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  logic [SRC_N-1:0] statW;

  // one cell per source: level sources track, pulse sources latch
  for (genvar i = 0; i < SRC_N; i++) begin : g_cell
    if (LEVEL_SRC[i]) begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rawQ[i] <= 1'b0;
        else       rawQ[i] <= srcIn[i];
      end
    end else begin : g_pulse
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rawQ[i] <= 1'b0;
        else       rawQ[i] <= srcIn[i] | (rawQ[i] & ~stb.clrSrc[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskQ <= MASK_RESET;
    else if (stb.maskWr) maskQ <= maskIn;
  end

  // new cause bits win over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= causeIn | (causeQ & {CAUSE_N{~stb.clrCause}});
  end

  assign statW = rawQ & maskQ;
  assign irq   = |statW;

  always_comb begin
    unique case (stb.rdSel)
      SEL_RAW:     rdData = DATA_W'(rawQ);
      SEL_MASK:    rdData = DATA_W'(maskQ);
      SEL_STAT:    rdData = DATA_W'(statW);
      SEL_CAUSE:   rdData = DATA_W'(causeQ);
      SEL_CLR_ONE: rdData = DATA_W'(rawQ[stb.srcIdx]);
      SEL_CLR_ALL: rdData = DATA_W'(rawQ);
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/intr_status_block.sv
module intr_status_block
  import intr_status_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_N-1:0]   srcIn,
  input  logic [CAUSE_N-1:0] causeIn,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  strobes_t           stb;
  logic [SRC_N-1:0]   rawQ;
  logic [SRC_N-1:0]   maskQ;
  logic [CAUSE_N-1:0] causeQ;
  logic               unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:SRC_N];

  intr_status_decode #(
    .ADDR_W (ADDR_W)
  ) u_decode (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  intr_status_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .srcIn   (srcIn),
    .causeIn (causeIn),
    .maskIn  (wrData[SRC_N-1:0]),
    .rawQ    (rawQ),
    .maskQ   (maskQ),
    .causeQ  (causeQ),
    .rdData  (rdData),
    .irq     (irq)
  );

endmodule

// File: rtl/intr_status_chk.sv
module intr_status_chk
  import intr_status_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [SRC_N-1:0]   srcIn,
  input logic [SRC_N-1:0]   rawQ,
  input logic [CAUSE_N-1:0] causeIn,
  input logic [CAUSE_N-1:0] causeQ
);

  logic clrAllRd, clrAbrtRd;
  assign clrAllRd  = rdEn && (addr == ADDR_W'(ADDR_CLR_ALL));
  assign clrAbrtRd = rdEn && (addr == ADDR_W'(CLR_BASE + TXABRT_BIT));

  // R3: a set stop-seen bit survives any cycle without a clear read for it
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rawQ[9] && !(rdEn && (addr == ADDR_W'(CLR_BASE + 9))) && !clrAllRd) |=> rawQ[9]);

  // R4: clearing the abort bit without a new pulse leaves it low
  p_clear_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clrAbrtRd && !srcIn[TXABRT_BIT]) |=> !rawQ[TXABRT_BIT]);

  // R5: combined clear with no new input empties pulse bits and the cause word
  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrAllRd && (srcIn == '0) && (causeIn == '0)) |=> (((rawQ & ~LEVEL_SRC) == '0) && (causeQ == '0)));

  // R6: receive-full bit mirrors the previous-cycle level
  p_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rawQ[RXFULL_BIT] == $past(srcIn[RXFULL_BIT])));

  // R7: cause bits never drop without a clearing read
  p_cause_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(clrAbrtRd || clrAllRd) |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  // R9: a pulse racing its own clear read wins
  p_race_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == ADDR_W'(CLR_BASE)) && srcIn[0]) |=> rawQ[0]);

endmodule

bind intr_status_block intr_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdEn    (rdEn),
  .addr    (addr),
  .srcIn   (srcIn),
  .rawQ    (rawQ),
  .causeIn (causeIn),
  .causeQ  (causeQ)
);

// File: tb/intr_status_block_test.sv
module intr_status_block_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] LVL = 12'h014;
  localparam logic [11:0] PULSE_ALL = 12'hFEB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] srcIn = '0;
  logic [12:0] causeIn = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [11:0] lvl = '0;
  logic [11:0] expRaw = '0;
  logic [11:0] expMask = 12'h254;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_status_block uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .causeIn(causeIn),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [5:0] a, output logic [31:0] data);
    rdEn = 1'b1;
    addr = a;
    #1 data = rdData;
    tick();
    rdEn = 1'b0;
    addr = '0;
  endtask

  task automatic writeMask(input logic [31:0] v);
    wrEn = 1'b1;
    addr = 6'h01;
    wrData = v;
    tick();
    wrEn = 1'b0;
    addr = '0;
  endtask

  task automatic pulse(input logic [11:0] v);
    srcIn = lvl | (v & ~LVL);
    tick();
    srcIn = lvl;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 irq in reset", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    readReg(6'h00, d); check("R1 raw after reset", d, 32'h0);
    readReg(6'h01, d); check("R8 mask reset", d, 32'h254);
    readReg(6'h04, d); check("R7 cause after reset", d, 32'h0);

    // per-source sweep
    for (int i = 0; i < 12; i++) begin
      if (LVL[i]) begin
        lvl = 12'(1 << i); srcIn = lvl;
        tick();
        readReg(6'h00, d); check("R6 level follows", d, 32'(lvl));
        readReg(6'(16 + i), d); check("R6 level clear read data", d, 32'h1);
        readReg(6'h00, d); check("R6 level not cleared", d, 32'(lvl));
        lvl = '0; srcIn = '0;
        tick();
        readReg(6'h00, d); check("R6 level drops", d, 32'h0);
      end else begin
        pulse(12'(1 << i));
        expRaw = 12'(1 << i);
        check("R2 irq", {31'b0, irq}, {31'b0, |(expRaw & expMask)});
        readReg(6'h00, d); check("R1 raw set", d, 32'(expRaw));
        readReg(6'h02, d); check("R2 masked", d, 32'(expRaw & expMask));
        repeat (4) tick();
        readReg(6'h00, d); check("R3 sticky", d, 32'(expRaw));
        readReg(6'(16 + i), d); check("R4 clear read data", d, 32'h1);
        readReg(6'h00, d); check("R4 cleared", d, 32'h0);
        readReg(6'(16 + i), d); check("R4 second clear reads zero", d, 32'h0);
      end
    end

    // isolation: clear one at a time with all others set
    pulse(PULSE_ALL);
    expRaw = PULSE_ALL;
    for (int i = 0; i < 12; i++) begin
      if (!LVL[i]) begin
        readReg(6'(16 + i), d);
        expRaw[i] = 1'b0;
        readReg(6'h00, d); check("R4 isolation", d, 32'(expRaw));
      end
    end

    // mask sweep with every raw bit set
    lvl = LVL; srcIn = lvl;
    pulse(PULSE_ALL);
    expRaw = 12'hFFF;
    for (int j = 0; j < 12; j++) begin
      writeMask(32'hFFFF_F000 | 32'(1 << j));
      expMask = 12'(1 << j);
      readReg(6'h01, d); check("R8 mask readback", d, 32'(expMask));
      readReg(6'h02, d); check("R2 masked single", d, 32'(expMask));
      check("R2 irq single", {31'b0, irq}, 32'h1);
    end
    writeMask(32'h0);
    expMask = '0;
    check("R2 irq masked off", {31'b0, irq}, 32'h0);
    readReg(6'h02, d); check("R2 masked zero", d, 32'h0);
    writeMask(32'h254);
    expMask = 12'h254;

    // combined clear
    causeIn = 13'h0808; tick(); causeIn = '0;
    readReg(6'h03, d); check("R5 clear-all read data", d, 32'hFFF);
    readReg(6'h00, d); check("R5 R6 after clear-all", d, 32'(LVL));
    readReg(6'h04, d); check("R5 cause cleared", d, 32'h0);
    lvl = '0; srcIn = '0; tick();

    // cause accumulation and hold
    causeIn = 13'h0001; tick();
    causeIn = 13'h1000; tick();
    causeIn = '0;
    repeat (3) tick();
    readReg(6'h04, d); check("R7 accumulate", d, 32'h1001);
    readReg(6'h00, d);
    readReg(6'(16 + 5), d);
    readReg(6'h04, d); check("R7 hold other reads", d, 32'h1001);
    readReg(6'(16 + 6), d);
    readReg(6'h04, d); check("R7 abort clear", d, 32'h0);
    for (int k = 0; k < 13; k++) begin
      causeIn = 13'(1 << k); tick(); causeIn = '0;
      readReg(6'h04, d); check("R7 cause bit", d, 32'(1 << k));
      readReg(6'(16 + 6), d);
      readReg(6'h04, d); check("R7 cause bit cleared", d, 32'h0);
    end

    // same-cycle race
    pulse(12'h008);
    rdEn = 1'b1; addr = 6'(16 + 3); srcIn = 12'h008;
    tick();
    rdEn = 1'b0; addr = '0; srcIn = '0;
    readReg(6'h00, d); check("R9 pulse wins", d, 32'h008);
    readReg(6'(16 + 3), d);
    causeIn = 13'h0004; tick();
    rdEn = 1'b1; addr = 6'(16 + 6); causeIn = 13'h0010;
    tick();
    rdEn = 1'b0; addr = '0; causeIn = '0;
    readReg(6'h04, d); check("R9 cause wins", d, 32'h0010);
    readReg(6'h03, d);

    // unmapped read
    pulse(12'h200);
    readReg(6'h08, d); check("R10 unmapped zero", d, 32'h0);
    readReg(6'h3F, d); check("R10 unmapped top", d, 32'h0);
    readReg(6'h02, d); check("R10 status read", d, 32'h200);
    readReg(6'h00, d); check("R10 no side effect", d, 32'h200);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule